// File: doc/BRIEF.md
# Dual-Mode Vector Multiply-Accumulate Unit

This block is a row of eight signed 8-bit multipliers feeding a bank of 32-bit accumulators. A run-time mode bit decides how the products are used. In channel mode the eight products of a feature vector and a weight vector are added together, and that single sum builds up one output point along the input-channel direction. In spatial mode each multiplier feeds its own accumulator, so eight neighbouring output points of one row are produced at once. A 3-tap kernel is slid across a 10-byte feature window in three steps, and each step's tap is broadcast to all lanes.

A control sequencer drives one operation per cycle. It raises clear at the start of an output block, raises valid for each operand pair, and selects the tap step in spatial mode. When the block is finished it pulses done. One cycle later the unit flags its result as valid. The accumulators hold their contents until the next clear.

Top module: `vmac_top`

## Requirements
- R1: After synchronous reset every accumulator lane of `res_o` is zero and `res_vld_o` is low.
- R2: With `mode_i` = 0 (channel mode) and `vld_i` high, lane 0 adds the sum over j = 0..7 of feature byte j times weight byte j. Byte j of a vector sits at bits [8j+7:8j]. Lanes 1..7 keep their values.
- R3: With `mode_i` = 1 (spatial mode), `vld_i` high and `step_i` = k in 0..2, lane j adds feature byte j+k times weight byte k.
- R4: After steps 0, 1 and 2 in spatial mode, lane j holds the 3-tap result for output j (sum over k of feature byte j+k times weight byte k).
- R5: All operands are two's-complement signed. Each product is sign-extended to 32 bits before it is added, and the sum wraps modulo 2^32.
- R6: `clr_i` high with `vld_i` low sets every lane to zero on the next cycle.
- R7: `clr_i` and `vld_i` high in the same cycle discard the old contents. Each lane then holds only the current cycle's contribution.
- R8: With `clr_i` and `vld_i` both low, `res_o` keeps its value.
- R9: `res_vld_o` is high for exactly the cycle after each cycle in which `done_i` is high, and low otherwise.
- R10: In spatial mode a `step_i` value of 3 adds nothing. With `clr_i` low the lanes keep their values.

Lane j of `res_o` sits at bits [32j+31:32j].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | 0 = channel reduction, 1 = spatial per-lane |
| step_i | input | 2 | Kernel tap step in spatial mode |
| clr_i | input | 1 | Zero the accumulators (takes priority over their old contents) |
| vld_i | input | 1 | Operands valid; accumulate this cycle |
| done_i | input | 1 | Block finished; flag the result next cycle |
| feat_i | input | 80 | Ten feature bytes |
| wgt_i | input | 64 | Eight weight bytes |
| res_o | output | 256 | Eight 32-bit signed accumulator lanes |
| res_vld_o | output | 1 | Result valid pulse |

## Verification
Clear and accumulate can fall in the same cycle, because a new block's first operand pair arrives together with the clear. The bench raises both at once, in both modes and on accumulators already holding non-zero sums. The scoreboard then expects only that cycle's contribution, with nothing left over from earlier. The bench also pulses done in the same cycle as a final accumulate, and expects the flagged result to include that last contribution.

// File: rtl/vmac_pkg.sv
package vmac_pkg;

    typedef enum logic {
        MODE_CHANNEL = 1'b0,
        MODE_SPATIAL = 1'b1
    } mac_mode_e;

    localparam int VMAC_LANES = 8;
    localparam int VMAC_TAPS  = 3;
    localparam int VMAC_OPW   = 8;
    localparam int VMAC_ACCW  = 32;

    function automatic int step_bits(input int taps);
        return (taps > 1) ? $clog2(taps) : 1;
    endfunction

endpackage

// File: rtl/vmac_opsel.sv
module vmac_opsel
    import vmac_pkg::*;
#(
    parameter int LANES = VMAC_LANES,
    parameter int TAPS  = VMAC_TAPS,
    parameter int OPW   = VMAC_OPW,
    localparam int WIN  = LANES + TAPS - 1,
    localparam int SW   = step_bits(TAPS)
) (
    input  mac_mode_e                   mode_i,
    input  logic [SW-1:0]               step_i,
    input  logic [WIN*OPW-1:0]          feat_i,
    input  logic [LANES*OPW-1:0]        wgt_i,
    output logic [LANES-1:0][OPW-1:0]   a_o,
    output logic [LANES-1:0][OPW-1:0]   b_o
);

    // Channel mode: lane-aligned pairs. Spatial mode: window shifted by the
    // step, weight tap broadcast; an unused step value gives zero operands.
    always_comb begin
        for (int j = 0; j < LANES; j++) begin
            a_o[j] = feat_i[j*OPW +: OPW];
            b_o[j] = wgt_i[j*OPW +: OPW];
            if (mode_i == MODE_SPATIAL) begin
                a_o[j] = '0;
                b_o[j] = '0;
                for (int k = 0; k < TAPS; k++) begin
                    if (step_i == SW'(k)) begin
                        a_o[j] = feat_i[(j+k)*OPW +: OPW];
                        b_o[j] = wgt_i[k*OPW +: OPW];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/vmac_mularray.sv
module vmac_mularray
    import vmac_pkg::*;
#(
    parameter int LANES = VMAC_LANES,
    parameter int OPW   = VMAC_OPW,
    localparam int PW   = 2 * OPW
) (
    input  logic [LANES-1:0][OPW-1:0] a_i,
    input  logic [LANES-1:0][OPW-1:0] b_i,
    output logic [LANES-1:0][PW-1:0]  prod_o
);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign prod_o[j] = $signed(a_i[j]) * $signed(b_i[j]);
    end

endmodule

// File: rtl/vmac_reduce.sv
module vmac_reduce
    import vmac_pkg::*;
#(
    parameter int LANES = VMAC_LANES,
    parameter int PW    = 2 * VMAC_OPW,
    parameter int ACCW  = VMAC_ACCW
) (
    input  logic [LANES-1:0][PW-1:0] prod_i,
    output logic [ACCW-1:0]          sum_o
);

    always_comb begin
        sum_o = '0;
        for (int j = 0; j < LANES; j++) begin
            sum_o = sum_o + {{(ACCW-PW){prod_i[j][PW-1]}}, prod_i[j]};
        end
    end

endmodule

// File: rtl/vmac_accbank.sv
module vmac_accbank
    import vmac_pkg::*;
#(
    parameter int LANES = VMAC_LANES,
    parameter int PW    = 2 * VMAC_OPW,
    parameter int ACCW  = VMAC_ACCW
) (
    input  logic                      clk,
    input  logic                      rst,
    input  mac_mode_e                 mode_i,
    input  logic                      clr_i,
    input  logic                      vld_i,
    input  logic [LANES-1:0][PW-1:0]  prod_i,
    input  logic [ACCW-1:0]           sum_i,
    output logic [LANES-1:0][ACCW-1:0] acc_o
);

    logic [LANES-1:0][ACCW-1:0] add_w;
    logic [LANES-1:0][ACCW-1:0] base_w;

    always_comb begin
        for (int j = 0; j < LANES; j++) begin
            if (mode_i == MODE_SPATIAL) begin
                add_w[j] = {{(ACCW-PW){prod_i[j][PW-1]}}, prod_i[j]};
            end else begin
                add_w[j] = (j == 0) ? sum_i : '0;
            end
            base_w[j] = clr_i ? '0 : acc_o[j];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_o <= '0;
        end else if (vld_i) begin
            for (int j = 0; j < LANES; j++) begin
                acc_o[j] <= base_w[j] + add_w[j];
            end
        end else if (clr_i) begin
            acc_o <= '0;
        end
    end

endmodule

// File: rtl/vmac_top.sv
module vmac_top
    import vmac_pkg::*;
#(
    parameter int LANES = VMAC_LANES,
    parameter int TAPS  = VMAC_TAPS,
    parameter int OPW   = VMAC_OPW,
    parameter int ACCW  = VMAC_ACCW,
    localparam int WIN  = LANES + TAPS - 1,
    localparam int PW   = 2 * OPW,
    localparam int SW   = step_bits(TAPS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    mode_i,
    input  logic [SW-1:0]           step_i,
    input  logic                    clr_i,
    input  logic                    vld_i,
    input  logic                    done_i,
    input  logic [WIN*OPW-1:0]      feat_i,
    input  logic [LANES*OPW-1:0]    wgt_i,
    output logic [LANES*ACCW-1:0]   res_o,
    output logic                    res_vld_o
);

    mac_mode_e                   mode_w;
    logic [LANES-1:0][OPW-1:0]   a_w;
    logic [LANES-1:0][OPW-1:0]   b_w;
    logic [LANES-1:0][PW-1:0]    prod_w;
    logic [ACCW-1:0]             sum_w;
    logic [LANES-1:0][ACCW-1:0]  acc_w;

    assign mode_w = mac_mode_e'(mode_i);

    vmac_opsel #(.LANES(LANES), .TAPS(TAPS), .OPW(OPW)) u_opsel (
        .mode_i (mode_w),
        .step_i (step_i),
        .feat_i (feat_i),
        .wgt_i  (wgt_i),
        .a_o    (a_w),
        .b_o    (b_w)
    );

    vmac_mularray #(.LANES(LANES), .OPW(OPW)) u_mul (
        .a_i    (a_w),
        .b_i    (b_w),
        .prod_o (prod_w)
    );

    vmac_reduce #(.LANES(LANES), .PW(PW), .ACCW(ACCW)) u_red (
        .prod_i (prod_w),
        .sum_o  (sum_w)
    );

    vmac_accbank #(.LANES(LANES), .PW(PW), .ACCW(ACCW)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .mode_i (mode_w),
        .clr_i  (clr_i),
        .vld_i  (vld_i),
        .prod_i (prod_w),
        .sum_i  (sum_w),
        .acc_o  (acc_w)
    );

    assign res_o = acc_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_vld_o <= 1'b0;
        end else begin
            res_vld_o <= done_i;
        end
    end

endmodule

// File: rtl/vmac_chk.sv
module vmac_chk #(
    parameter int LANES = 8,
    parameter int TAPS  = 3,
    parameter int ACCW  = 32,
    parameter int SW    = 2
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  mode_i,
    input logic [SW-1:0]         step_i,
    input logic                  clr_i,
    input logic                  vld_i,
    input logic                  done_i,
    input logic [LANES*ACCW-1:0] res_o,
    input logic                  res_vld_o
);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (res_o == '0 && !res_vld_o));

    p_upper_lanes_kept_r2: assert property (@(posedge clk) disable iff (rst)
        (vld_i && !clr_i && !mode_i) |=> $stable(res_o[LANES*ACCW-1:ACCW]));

    p_clear_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !vld_i) |=> (res_o == '0));

    p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !vld_i) |=> $stable(res_o));

    p_done_flag_r9: assert property (@(posedge clk) disable iff (rst)
        done_i |=> res_vld_o);

    p_no_stray_flag_r9: assert property (@(posedge clk) disable iff (rst)
        !done_i |=> !res_vld_o);

    p_bad_step_r10: assert property (@(posedge clk) disable iff (rst)
        (vld_i && !clr_i && mode_i && int'(step_i) >= TAPS) |=> $stable(res_o));

endmodule

bind vmac_top vmac_chk #(
    .LANES (LANES),
    .TAPS  (TAPS),
    .ACCW  (ACCW),
    .SW    (SW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_i    (mode_i),
    .step_i    (step_i),
    .clr_i     (clr_i),
    .vld_i     (vld_i),
    .done_i    (done_i),
    .res_o     (res_o),
    .res_vld_o (res_vld_o)
);

// File: tb/vmac_top_tb.sv
module vmac_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LANES = 8;
    localparam int ACCW  = 32;
    localparam int FW    = 80;
    localparam int WW    = 64;

    typedef struct {
        logic [LANES*ACCW-1:0] res;
        string                 tag;
    } exp_t;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  mode_i = 1'b0;
    logic [1:0]            step_i = '0;
    logic                  clr_i = 1'b0;
    logic                  vld_i = 1'b0;
    logic                  done_i = 1'b0;
    logic [FW-1:0]         feat_i = '0;
    logic [WW-1:0]         wgt_i = '0;
    logic [LANES*ACCW-1:0] res_o;
    logic                  res_vld_o;

    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;
    int   mdl [LANES];
    exp_t q [$];

    vmac_top u_dut (
        .clk       (clk),
        .rst       (rst),
        .mode_i    (mode_i),
        .step_i    (step_i),
        .clr_i     (clr_i),
        .vld_i     (vld_i),
        .done_i    (done_i),
        .feat_i    (feat_i),
        .wgt_i     (wgt_i),
        .res_o     (res_o),
        .res_vld_o (res_vld_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [LANES*ACCW-1:0] pack_mdl();
        logic [LANES*ACCW-1:0] v;
        for (int j = 0; j < LANES; j++) v[j*ACCW +: ACCW] = mdl[j];
        return v;
    endfunction

    function automatic logic [FW-1:0] rnd_f();
        logic [FW-1:0] v;
        for (int i = 0; i < FW/8; i++) v[i*8 +: 8] = 8'($urandom);
        return v;
    endfunction

    function automatic logic [WW-1:0] rnd_w();
        logic [WW-1:0] v;
        for (int i = 0; i < WW/8; i++) v[i*8 +: 8] = 8'($urandom);
        return v;
    endfunction

    // Driver: applies one cycle of stimulus, updates the model, queues the
    // expected result when done is raised.
    task automatic op(input bit m, input int k, input bit c, input bit v,
                      input bit d, input logic [FW-1:0] f,
                      input logic [WW-1:0] w, input string tag);
        int addv [LANES];
        @(negedge clk);
        mode_i = m; step_i = 2'(k); clr_i = c; vld_i = v; done_i = d;
        feat_i = f; wgt_i = w;
        for (int j = 0; j < LANES; j++) addv[j] = 0;
        if (!m) begin
            for (int j = 0; j < LANES; j++)
                addv[0] += int'($signed(f[j*8 +: 8])) * int'($signed(w[j*8 +: 8]));
        end else if (k < 3) begin
            for (int j = 0; j < LANES; j++)
                addv[j] = int'($signed(f[(j+k)*8 +: 8])) * int'($signed(w[k*8 +: 8]));
        end
        for (int j = 0; j < LANES; j++) begin
            if (v) mdl[j] = (c ? 0 : mdl[j]) + addv[j];
            else if (c) mdl[j] = 0;
        end
        if (d) begin
            exp_t e;
            e.res = pack_mdl();
            e.tag = tag;
            q.push_back(e);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) op(0, 0, 0, 0, 0, '0, '0, "");
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && res_vld_o) begin
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL R9: result flag with nothing expected, got res=%h exp=none", res_o);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (res_o !== e.res) begin
                    errors++;
                    $display("FAIL %s: res=%h exp=%h", e.tag, res_o, e.res);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, got running exp=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [FW-1:0] f;
        logic [WW-1:0] w;
        for (int j = 0; j < LANES; j++) mdl[j] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        checks++;
        if (res_o !== '0 || res_vld_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: res=%h vld=%b exp=0 vld=0", res_o, res_vld_o);
        end

        // R2: channel mode, small positive values
        f = '0; w = '0;
        for (int j = 0; j < 8; j++) begin
            f[j*8 +: 8] = 8'(j + 1);
            w[j*8 +: 8] = 8'(2);
        end
        op(0, 0, 1, 1, 1, f, w, "R2 channel sum");
        idle(2);

        // R5: channel accumulate with mixed signs over two vectors
        op(0, 0, 1, 1, 0, rnd_f(), rnd_w(), "R5");
        op(0, 0, 0, 1, 1, rnd_f(), rnd_w(), "R5 signed channel accumulate");
        idle(2);

        // R5: extreme operands, -128 * -128 in every lane
        f = {10{8'h80}}; w = {8{8'h80}};
        op(0, 0, 1, 1, 0, f, w, "");
        op(0, 0, 0, 1, 1, f, {8{8'h7f}}, "R5 extreme operands");
        idle(1);

        // R3 / R4: spatial 3-tap convolution
        f = rnd_f(); w = rnd_w();
        op(1, 0, 1, 1, 0, f, w, "");
        op(1, 1, 0, 1, 1, f, w, "R3 spatial two steps");
        op(1, 2, 0, 1, 1, f, w, "R4 spatial three taps");
        idle(1);

        // R2: channel vld after spatial sums: upper lanes keep values
        op(0, 0, 0, 1, 1, rnd_f(), rnd_w(), "R2 upper lanes kept");

        // R7: clear with valid over non-zero contents, spatial then channel
        op(1, 1, 1, 1, 1, rnd_f(), rnd_w(), "R7 clear+valid spatial");
        op(1, 2, 0, 1, 0, rnd_f(), rnd_w(), "");
        op(0, 0, 1, 1, 1, rnd_f(), rnd_w(), "R7 clear+valid channel");

        // R10: unused step value in spatial mode
        op(1, 0, 1, 1, 0, rnd_f(), rnd_w(), "");
        op(1, 3, 0, 1, 1, rnd_f(), rnd_w(), "R10 step 3 adds nothing");

        // R8: idle cycles hold the sum
        idle(4);
        op(0, 0, 0, 0, 1, rnd_f(), rnd_w(), "R8 hold while idle");

        // R6: clear alone
        op(1, 0, 1, 0, 0, rnd_f(), rnd_w(), "");
        op(0, 0, 0, 0, 1, '0, '0, "R6 clear zeroes lanes");

        // R9: back-to-back done pulses
        op(1, 0, 1, 1, 1, rnd_f(), rnd_w(), "R9 back-to-back a");
        op(1, 1, 0, 1, 1, rnd_f(), rnd_w(), "R9 back-to-back b");

        // R3 / R2: random blocks in both modes
        for (int it = 0; it < 10; it++) begin
            f = rnd_f(); w = rnd_w();
            if (it % 2 == 0) begin
                op(1, 0, 1, 1, 0, f, w, "");
                op(1, 1, 0, 1, 0, f, w, "");
                op(1, 2, 0, 1, 1, f, w, "R3 random spatial block");
            end else begin
                op(0, 0, 1, 1, 0, f, w, "");
                op(0, 0, 0, 1, 0, rnd_f(), rnd_w(), "");
                op(0, 0, 0, 1, 1, rnd_f(), rnd_w(), "R2 random channel block");
            end
        end
        idle(4);

        // R9: every done produced exactly one flagged result
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R9: pending=%0d exp=0", q.size());
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule